// File: doc/BRIEF.md
# Single-Precision Floating-Point Equality Unit

This execution unit compares two single-precision operands under quiet-equality rules. It takes a 32-bit instruction word together with the two operand values read from the floating-point register file. It returns a 0/1 integer result zero-extended to the integer register width, the destination index decoded from the instruction word, and an invalid-operation indication. The invalid indication is merged into a sticky five-bit exception-flag register, which software clears through a dedicated input.

An unordered pair, where either operand is a NaN, compares false. Signed zeros compare equal. Only a signaling NaN raises invalid. Every comparison completes in one registered cycle, whatever the operand values, so the unit's timing does not depend on the data.

Top module: `fp_eq_unit`

## Requirements
- R1: One clock edge after `req_valid` is sampled high, `rsp_valid` is high. After an edge where `req_valid` is low, `rsp_valid` is low.
- R2: For two non-NaN operands that are not both zero, `rsp_result` is 1 exactly when all 32 bits match. This includes infinities of the same sign. The upper `XLEN-1` bits of `rsp_result` are always 0.
- R3: If either operand is a NaN, `rsp_result` is 0. A NaN has bits 30:23 all ones and bits 22:0 non-zero.
- R4: When bits 30:0 of both operands are zero, `rsp_result` is 1 whatever the sign bits are.
- R5: `rsp_invalid` is 1 exactly when an accepted operand is a signaling NaN, meaning bit 22 is 0. A quiet NaN, with bit 22 equal to 1, does not raise it.
- R6: `rsp_rd` equals bits 11:7 of the accepted instruction word. `src1_idx` is bits 19:15 and `src2_idx` is bits 24:20, combinationally.
- R7: Operand A is compared as the first source and operand B as the second. Each operand is used once.
- R8: `fflags` bit 4 (invalid) is set on the edge that captures a signaling-NaN request. It stays set until `flags_clr` or reset. Bits 3:0 stay 0.
- R9: A request with `req_valid` low accrues no flag. Reset sets all outputs to 0.
- R10: While `req_valid` is low, `rsp_result` and `rsp_rd` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_insn | input | 32 | Instruction word |
| op_a | input | 32 | First source operand |
| op_b | input | 32 | Second source operand |
| flags_clr | input | 1 | Clear accrued flags |
| src1_idx | output | 5 | First source index |
| src2_idx | output | 5 | Second source index |
| rsp_valid | output | 1 | Response valid |
| rsp_result | output | XLEN | 0/1 comparison result |
| rsp_rd | output | 5 | Destination index |
| rsp_invalid | output | 1 | Invalid raised by this response |
| fflags | output | 5 | Sticky exception flags |

## Verification
Every response output, including the accrued flags, is due exactly one clock edge after the request is presented. The source indices are combinational and are valid in the same cycle. The bench drives each request on the falling edge and lets one rising edge pass. It then checks the registered outputs at the next falling edge against its own model. Checks of the clear input and of the hold behaviour follow the same one-edge rule.

// File: rtl/fp_eq_pkg.sv
// Package: shared constants for the equality unit.
// Assumes IEEE single-precision layout.
package fp_eq_pkg;
    localparam int SP_W      = 32;
    localparam int EXP_HI    = 30;
    localparam int EXP_LO    = 23;
    localparam int QUIET_BIT = 22;
    localparam int FLAG_W    = 5;
    localparam int FLAG_NV   = 4;
    localparam int IDX_W     = 5;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic mag_zero;
    } sp_class_t;
endpackage

// File: rtl/fp_sp_classify.sv
// Classifies one single-precision value as NaN, signaling NaN or zero magnitude.
// Assumes a plain 32-bit IEEE encoding. Purely combinational.
module fp_sp_classify
    import fp_eq_pkg::*;
(
    input  logic [SP_W-1:0] val,
    output sp_class_t       cls
);
    logic exp_ones;
    logic frac_nz;

    // Derive the class bits from the exponent and fraction fields.
    always_comb begin
        exp_ones     = &val[EXP_HI:EXP_LO];
        frac_nz      = |val[EXP_LO-1:0];
        cls.is_nan   = exp_ones && frac_nz;
        cls.is_snan  = exp_ones && frac_nz && !val[QUIET_BIT];
        cls.mag_zero = ~|val[SP_W-2:0];
    end
endmodule

// File: rtl/fp_eq_compare.sv
// Quiet-equality core: unordered gives false, signed zeros are equal,
// and only a signaling NaN raises invalid. Combinational, with the same
// logic depth for every operand pair.
module fp_eq_compare
    import fp_eq_pkg::*;
(
    input  logic [SP_W-1:0] a,
    input  logic [SP_W-1:0] b,
    output logic            eq,
    output logic            invalid
);
    sp_class_t ca, cb;

    fp_sp_classify u_cls_a (.val(a), .cls(ca));
    fp_sp_classify u_cls_b (.val(b), .cls(cb));

    // Combine the operand classes into the equality and invalid results.
    always_comb begin
        invalid = ca.is_snan || cb.is_snan;
        if (ca.is_nan || cb.is_nan)
            eq = 1'b0;
        else
            eq = (a == b) || (ca.mag_zero && cb.mag_zero);
    end

    always_comb begin
        assert_nan_false_R3: assert (!(ca.is_nan || cb.is_nan) || !eq);
        assert_qnan_quiet_R5: assert (!(ca.is_nan && !ca.is_snan && !cb.is_snan) || !invalid);
    end
endmodule

// File: rtl/fp_eq_flags.sv
// Sticky accrued exception-flag register. Bits are only set by the unit
// and cleared by an explicit clear input or by reset.
module fp_eq_flags
    import fp_eq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              set_nv,
    output logic [FLAG_W-1:0] flags
);
    // Accrue the invalid flag; clear has priority over a set.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            flags <= '0;
        else if (set_nv)
            flags[FLAG_NV] <= 1'b1;
    end

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLAG_NV] && !clr) |=> flags[FLAG_NV]);
    assert_low_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flags[FLAG_NV-1:0] == '0);
endmodule

// File: rtl/fp_eq_unit.sv
// Top of the floating-point equality execution unit. It decodes the register
// fields, compares the two operands and registers the result with a fixed
// one-cycle latency. Assumes the caller has already read the operands for
// src1_idx and src2_idx in the request cycle.
module fp_eq_unit
    import fp_eq_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_insn,
    input  logic [SP_W-1:0]   op_a,
    input  logic [SP_W-1:0]   op_b,
    input  logic              flags_clr,
    output logic [IDX_W-1:0]  src1_idx,
    output logic [IDX_W-1:0]  src2_idx,
    output logic              rsp_valid,
    output logic [XLEN-1:0]   rsp_result,
    output logic [IDX_W-1:0]  rsp_rd,
    output logic              rsp_invalid,
    output logic [FLAG_W-1:0] fflags
);
    localparam int PAD_W = XLEN - 1;

    logic eq_c, inv_c, res_bit;

    // Decode the source register fields from the instruction word.
    always_comb begin
        src1_idx = req_insn[19:15];
        src2_idx = req_insn[24:20];
    end

    fp_eq_compare u_cmp (.a(op_a), .b(op_b), .eq(eq_c), .invalid(inv_c));

    // Register the response; result and rd hold while no request arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            res_bit     <= 1'b0;
            rsp_rd      <= '0;
            rsp_invalid <= 1'b0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_invalid <= req_valid && inv_c;
            if (req_valid) begin
                res_bit <= eq_c;
                rsp_rd  <= req_insn[11:7];
            end
        end
    end

    assign rsp_result = {{PAD_W{1'b0}}, res_bit};

    fp_eq_flags u_flags (
        .clk(clk), .rst_n(rst_n), .clr(flags_clr),
        .set_nv(req_valid && inv_c), .flags(fflags)
    );

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_rd == $past(req_insn[11:7]));
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_result) && $stable(rsp_rd)));
    assert_no_accrue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !fflags[FLAG_NV]) |=> !fflags[FLAG_NV]);
    assert_zero_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_result[XLEN-1:1] == '0);
endmodule

// File: tb/sim_fp_eq_unit.sv
module sim_fp_eq_unit;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 64;

    logic clk = 0, rst_n = 0, req_valid = 0, flags_clr = 0;
    logic [31:0] req_insn = 0, op_a = 0, op_b = 0;
    logic [4:0] src1_idx, src2_idx, rsp_rd, fflags;
    logic rsp_valid, rsp_invalid;
    logic [XLEN-1:0] rsp_result;
    int checks = 0, fails = 0;
    logic sticky = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_eq_unit #(.XLEN(XLEN)) u0 (.*);

    function automatic bit m_nan(input logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction
    function automatic bit m_snan(input logic [31:0] v);
        return m_nan(v) && !v[22];
    endfunction
    function automatic bit m_eq(input logic [31:0] a, input logic [31:0] b);
        if (m_nan(a) || m_nan(b)) return 0;
        if (a[30:0] == 0 && b[30:0] == 0) return 1;
        return a == b;
    endfunction

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] a, input logic [31:0] b, input string tag);
        logic [31:0] insn;
        bit e, inv;
        insn = $urandom;
        @(negedge clk);
        req_valid = 1; op_a = a; op_b = b; req_insn = insn;
        #1;
        chk("R6 src1", src1_idx, insn[19:15]);
        chk("R6 src2", src2_idx, insn[24:20]);
        e = m_eq(a, b); inv = m_snan(a) || m_snan(b);
        if (inv) sticky = 1;
        @(negedge clk);
        req_valid = 0;
        chk({tag, " R1 valid"}, rsp_valid, 1);
        chk({tag, " R2/R3/R4/R7 result"}, rsp_result, {63'b0, e});
        chk({tag, " R5 invalid"}, rsp_invalid, inv);
        chk({tag, " R6 rd"}, rsp_rd, insn[11:7]);
        chk({tag, " R8 fflags"}, fflags, {sticky, 4'b0});
    endtask

    initial begin : wd
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] hr, hd;
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        chk("R9 reset valid", rsp_valid, 0);
        chk("R9 reset result", rsp_result, 0);
        chk("R9 reset flags", fflags, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 idle", rsp_valid, 0);
        issue(32'h3f800000, 32'h3f800000, "eq one");
        issue(32'h3f800000, 32'h40000000, "ne");
        issue(32'h00000000, 32'h80000000, "R4 zeros");
        issue(32'h80000000, 32'h80000000, "R4 negzeros");
        issue(32'h7f800000, 32'h7f800000, "R2 inf");
        issue(32'h7f800000, 32'hff800000, "R2 inf sign");
        issue(32'h7fc00000, 32'h7fc00000, "R3 qnan");
        chk("R5 qnan no flag", fflags, 0);
        issue(32'h00000001, 32'h80000001, "R2 denorm sign");
        issue(32'h3f800000, 32'h7fc00000, "R7 b qnan");
        issue(32'h7fc00000, 32'h3f800000, "R7 a qnan");
        chk("R5 qnan only", fflags, 0);
        issue(32'h7f800001, 32'h3f800000, "R5 snan a");
        // R8 clear
        @(negedge clk); flags_clr = 1;
        @(negedge clk); flags_clr = 0; sticky = 0;
        chk("R8 cleared", fflags, 0);
        issue(32'h3f800000, 32'h7fa00000, "R5 snan b");
        // R9 / R10: snan presented without valid, outputs held
        hr = rsp_result; hd = {27'b0, rsp_rd};
        @(negedge clk); flags_clr = 1;
        @(negedge clk); flags_clr = 0; sticky = 0;
        op_a = 32'h7f800001; op_b = 32'h7f800001; req_insn = 32'hffffffff;
        @(negedge clk);
        chk("R9 no accrue", fflags, 0);
        chk("R9 no valid", rsp_valid, 0);
        chk("R10 result hold", rsp_result, {32'b0, hr});
        chk("R10 rd hold", rsp_rd, hd[4:0]);
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a, b;
            a = $urandom; b = ($urandom % 4 == 0) ? a : $urandom;
            case ($urandom % 6)
                0: a[30:23] = 8'hFF;
                1: b[30:0] = 0;
                2: a[30:0] = 0;
                default: ;
            endcase
            issue(a, b, "rand");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule